// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This unit sits beside a pulse counter and decides when that counter should be cleared. Whenever a trigger occurs, it tests the counter's present value against a TOP value using one of three compare rules. On a match it raises a clear request and a match event together for exactly one cycle. A trigger that finds no match produces nothing.

A trigger comes from one of two sources. The first is a sampling-clock tick (`tick_i`) divided by 1, 2, 4 or 8. The second is one edge of an asynchronous event input, with the edge chosen by a polarity bit. That same input, after it has been synchronised and interpreted through the same polarity bit, can also hold the counter's clock enable low. Gating is switched on by its own bit and works in any trigger mode, including disabled.

The control is a three-state machine:
- **ST_OFF** means no trigger source is selected.
- **ST_ARMED** means a source is selected and the unit is waiting for a matching trigger.
- **ST_FIRE** is the single cycle in which the clear request and match event are driven.

The transitions are as follows:
- **OFF→ARMED**: a source has been selected.
- **ARMED→FIRE**, **OFF→FIRE** and **FIRE→FIRE**: a trigger matched.
- **FIRE→ARMED**: no further hit arrived and the source is still selected.
- **ARMED→OFF** and **FIRE→OFF**: the source was deselected.

Top module: `tcc_unit`

## Requirements
- R1: After reset `clr_req_o` and `match_o` are 0 and `cnt_gate_o` is 1. With `trig_mode_i` = 2'b00 (disabled) or 2'b11 (reserved), no clear request is ever produced.
- R2: With `trig_mode_i` = 2'b01 (tick mode), a trigger can occur only in a cycle where `tick_i` is 1. A matching trigger shows on the outputs in the following cycle.
- R3: In tick mode, `presc_i` = 0, 1, 2 or 3 makes every 1st, 2nd, 4th or 8th tick a trigger. The first tick after tick mode is entered is always a trigger.
- R4: `cmp_mode_i` = 2'b00 matches when `cnt_i` <= `top_i`.
- R5: `cmp_mode_i` = 2'b01 matches when `cnt_i` >= `top_i`.
- R6: `cmp_mode_i` = 2'b10 matches when `top_i[7:0]` <= `cnt_i` <= `top_i[15:8]`. Code 2'b11 never matches.
- R7: With `trig_mode_i` = 2'b10 (edge mode), `pol_i` = 0 triggers on a rising edge of `evt_i` and `pol_i` = 1 triggers on a falling edge. The opposite edge does nothing. A matching edge driven before clock edge k shows on the outputs after clock edge k+2, because of two synchroniser flops and the state register.
- R8: In edge mode, neither `presc_i` nor `tick_i` has any effect.
- R9: When `gate_en_i` = 1, `cnt_gate_o` is 0 while the synchronised `evt_i` is high (`pol_i` = 0) or low (`pol_i` = 1). A level driven before edge k shows after edge k+1. When `gate_en_i` = 0, `cnt_gate_o` is 1. Gating does not depend on the trigger mode.
- R10: A matching trigger drives `clr_req_o` and `match_o` high together for one cycle per trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Current counter value |
| top_i | input | 16 | TOP value; in window mode the low byte is the lower bound and the high byte the upper bound |
| tick_i | input | 1 | Sampling tick used in tick mode |
| evt_i | input | 1 | Asynchronous external event input |
| trig_mode_i | input | 2 | 0 disabled, 1 tick, 2 edge, 3 reserved (disabled) |
| presc_i | input | 2 | Tick divider code: divide by 1, 2, 4 or 8 |
| cmp_mode_i | input | 2 | 0 less-or-equal, 1 greater-or-equal, 2 window, 3 never |
| pol_i | input | 1 | Event polarity for both the trigger edge and the gating level |
| gate_en_i | input | 1 | Enables gating of the counter clock |
| clr_req_o | output | 1 | One-cycle counter clear request |
| match_o | output | 1 | One-cycle compare-match event |
| cnt_gate_o | output | 1 | Counter clock enable (0 = gated) |

## Verification
The properties assume that the configuration inputs, `cnt_i` and `top_i` are synchronous to `clk` and hold steady from the trigger cycle until the pulse is checked. They compare each pulse with the previous cycle's values of those inputs. The bench changes every input only at falling clock edges. It changes the polarity or mode only while `evt_i` is steady and the unit is disabled, so no spurious edge is seen. It holds `evt_i` low during reset so that the synchroniser starts from a known level.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_TICK = 2'd1,
        TRIG_EDGE = 2'd2,
        TRIG_RSVD = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        CMP_LE   = 2'd0,
        CMP_GE   = 2'd1,
        CMP_WIN  = 2'd2,
        CMP_NONE = 2'd3
    } cmp_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } state_e;
endpackage

// File: rtl/tcc_presc.sv
module tcc_presc #(
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tick,
    input  logic [PSW-1:0] div_code,
    output logic           fire
);
    localparam int CTW = (1 << PSW) - 1;

    logic [CTW-1:0] acc;
    logic [CTW-1:0] mask;

    // Low div_code bits of the tick count must be zero for a trigger.
    assign mask = (CTW'(1) << div_code) - CTW'(1);
    assign fire = run && tick && ((acc & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (!run)
            acc <= '0;
        else if (tick)
            acc <= acc + CTW'(1);
    end
endmodule

// File: rtl/tcc_sync_edge.sv
module tcc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic pol,
    output logic lvl,
    output logic edge_hit
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= evt;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl      = s2;
    assign edge_hit = pol ? (s3 && !s2) : (s2 && !s3);
endmodule

// File: rtl/tcc_cmp.sv
module tcc_cmp
    import tcc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] top,
    input  cmp_e          mode,
    output logic          match
);
    localparam int HW = CW / 2;

    logic [CW-1:0] lo_b, hi_b;

    assign lo_b = CW'(top[HW-1:0]);
    assign hi_b = CW'(top[CW-1:HW]);

    always_comb begin
        unique case (mode)
            CMP_LE:  match = (cnt <= top);
            CMP_GE:  match = (cnt >= top);
            CMP_WIN: match = (cnt >= lo_b) && (cnt <= hi_b);
            default: match = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
    import tcc_pkg::*;
#(
    parameter int CW  = 16,
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt_i,
    input  logic [CW-1:0]  top_i,
    input  logic           tick_i,
    input  logic           evt_i,
    input  logic [1:0]     trig_mode_i,
    input  logic [PSW-1:0] presc_i,
    input  logic [1:0]     cmp_mode_i,
    input  logic           pol_i,
    input  logic           gate_en_i,
    output logic           clr_req_o,
    output logic           match_o,
    output logic           cnt_gate_o
);
    trig_e  tmode;
    cmp_e   cmode;
    state_e state, state_nxt;
    logic   presc_fire, edge_hit, evt_lvl, cmp_hit, active, trig, hit;

    assign tmode = trig_e'(trig_mode_i);
    assign cmode = cmp_e'(cmp_mode_i);

    tcc_presc #(.PSW(PSW)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmode == TRIG_TICK),
        .tick     (tick_i),
        .div_code (presc_i),
        .fire     (presc_fire)
    );

    tcc_sync_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .pol      (pol_i),
        .lvl      (evt_lvl),
        .edge_hit (edge_hit)
    );

    tcc_cmp #(.CW(CW)) u_cmp (
        .cnt   (cnt_i),
        .top   (top_i),
        .mode  (cmode),
        .match (cmp_hit)
    );

    assign active = (tmode == TRIG_TICK) || (tmode == TRIG_EDGE);

    always_comb begin
        unique case (tmode)
            TRIG_TICK: trig = presc_fire;
            TRIG_EDGE: trig = edge_hit;
            default:   trig = 1'b0;
        endcase
    end

    assign hit = trig && cmp_hit;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (hit)         state_nxt = ST_FIRE;
                else if (active) state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit)          state_nxt = ST_FIRE;
                else if (!active) state_nxt = ST_OFF;
            end
            ST_FIRE: begin
                if (hit)         state_nxt = ST_FIRE;
                else if (active) state_nxt = ST_ARMED;
                else             state_nxt = ST_OFF;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nxt;
    end

    // Outputs
    always_comb begin
        clr_req_o  = (state == ST_FIRE);
        match_o    = (state == ST_FIRE);
        cnt_gate_o = !(gate_en_i && (evt_lvl != pol_i));
    end
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_i,
    input logic [CW-1:0] top_i,
    input logic          tick_i,
    input logic [1:0]    trig_mode_i,
    input logic [1:0]    cmp_mode_i,
    input logic          gate_en_i,
    input logic          clr_req_o,
    input logic          match_o,
    input logic          cnt_gate_o
);
    localparam int HW = CW / 2;

    logic [CW-1:0] lo_b, hi_b;
    assign lo_b = CW'(top_i[HW-1:0]);
    assign hi_b = CW'(top_i[CW-1:HW]);

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trig_mode_i) == 2'd0 || $past(trig_mode_i) == 2'd3) |-> !clr_req_o);

    p_tick_needed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_o && $past(trig_mode_i) == 2'd1) |-> $past(tick_i));

    p_le_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_o && $past(cmp_mode_i) == 2'd0) |-> ($past(cnt_i) <= $past(top_i)));

    p_ge_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_o && $past(cmp_mode_i) == 2'd1) |-> ($past(cnt_i) >= $past(top_i)));

    p_win_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_o && $past(cmp_mode_i) == 2'd2) |->
        (($past(cnt_i) >= $past(lo_b)) && ($past(cnt_i) <= $past(hi_b))));

    p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmp_mode_i) == 2'd3) |-> !clr_req_o);

    p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en_i |-> cnt_gate_o);

    p_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> clr_req_o);
endmodule

bind tcc_unit tcc_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt_i),
    .top_i       (top_i),
    .tick_i      (tick_i),
    .trig_mode_i (trig_mode_i),
    .cmp_mode_i  (cmp_mode_i),
    .gate_en_i   (gate_en_i),
    .clr_req_o   (clr_req_o),
    .match_o     (match_o),
    .cnt_gate_o  (cnt_gate_o)
);

// File: tb/tb_tcc_unit.sv
module tb_tcc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic [15:0] top_i = '0;
    logic        tick_i = 1'b0;
    logic        evt_i = 1'b0;
    logic [1:0]  trig_mode_i = 2'd0;
    logic [1:0]  presc_i = 2'd0;
    logic [1:0]  cmp_mode_i = 2'd0;
    logic        pol_i = 1'b0;
    logic        gate_en_i = 1'b0;
    logic        clr_req_o, match_o, cnt_gate_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tcc_unit dut (.*);

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One tick with given compare inputs; pulse sampled one cycle later.
    task automatic one_tick(input string tag, input logic [1:0] cm,
                            input logic [15:0] c, input logic [15:0] t, input int exp);
        @(negedge clk);
        trig_mode_i = 2'd1; presc_i = 2'd0;
        cmp_mode_i = cm; cnt_i = c; top_i = t; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check({tag, " clr"}, int'(clr_req_o), exp);
        check({tag, " match"}, int'(match_o), exp);
        @(negedge clk);
        check({tag, " one-cycle R10"}, int'(clr_req_o), 0);
    endtask

    task automatic t_reset_r1;
        check("R1 reset clr", int'(clr_req_o), 0);
        check("R1 reset match", int'(match_o), 0);
        check("R1 reset gate", int'(cnt_gate_o), 1);
        for (int m = 0; m < 4; m += 3) begin
            int n = 0;
            @(negedge clk);
            trig_mode_i = 2'(m); cmp_mode_i = 2'd0; cnt_i = 0; top_i = 5; tick_i = 1'b1;
            repeat (4) begin
                @(negedge clk);
                if (clr_req_o) n++;
            end
            tick_i = 1'b0;
            check("R1 disabled/reserved no pulse", n, 0);
        end
    endtask

    task automatic t_compare;
        one_tick("R2 R4 le equal", 2'd0, 16'd5, 16'd5, 1);
        one_tick("R4 le above", 2'd0, 16'd6, 16'd5, 0);
        one_tick("R5 ge equal", 2'd1, 16'd5, 16'd5, 1);
        one_tick("R5 ge below", 2'd1, 16'd4, 16'd5, 0);
        one_tick("R6 win low bound", 2'd2, 16'h0010, 16'h2010, 1);
        one_tick("R6 win high bound", 2'd2, 16'h0020, 16'h2010, 1);
        one_tick("R6 win under", 2'd2, 16'h000F, 16'h2010, 0);
        one_tick("R6 win over", 2'd2, 16'h0021, 16'h2010, 0);
        one_tick("R6 win high byte of count", 2'd2, 16'h0115, 16'h2010, 0);
        one_tick("R6 code 3 never", 2'd3, 16'd0, 16'd0, 0);
        // R2: no tick, no trigger
        @(negedge clk);
        cmp_mode_i = 2'd0; cnt_i = 0; top_i = 9; tick_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 no tick no pulse", int'(clr_req_o), 0);
    endtask

    task automatic t_presc_r3;
        for (int d = 0; d < 4; d++) begin
            int n = 0;
            @(negedge clk);
            trig_mode_i = 2'd0; tick_i = 1'b0;
            @(negedge clk);
            trig_mode_i = 2'd1; presc_i = 2'(d); cmp_mode_i = 2'd0;
            cnt_i = 0; top_i = 100; tick_i = 1'b1;
            repeat (8) begin
                @(negedge clk);
                if (clr_req_o) n++;
            end
            tick_i = 1'b0;
            check($sformatf("R3 div code %0d pulses in 8 ticks", d), n, 8 >> d);
        end
        @(negedge clk);
        trig_mode_i = 2'd0;
    endtask

    task automatic set_edge_mode(input logic p);
        @(negedge clk);
        trig_mode_i = 2'd0; pol_i = p; evt_i = p; gate_en_i = 1'b0;
        cmp_mode_i = 2'd0; cnt_i = 0; top_i = 1;
        repeat (4) @(negedge clk);
        trig_mode_i = 2'd2;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_edge_r7(input logic p);
        int n = 0;
        set_edge_mode(p);
        evt_i = ~p;
        @(negedge clk); check($sformatf("R7 pol%0d latency c1", p), int'(clr_req_o), 0);
        @(negedge clk); check($sformatf("R7 pol%0d latency c2", p), int'(clr_req_o), 0);
        @(negedge clk); check($sformatf("R7 pol%0d pulse c3", p), int'(clr_req_o), 1);
        @(negedge clk); check($sformatf("R7 pol%0d end c4", p), int'(clr_req_o), 0);
        evt_i = p;
        repeat (6) begin
            @(negedge clk);
            if (clr_req_o) n++;
        end
        check($sformatf("R7 pol%0d opposite edge ignored", p), n, 0);
    endtask

    task automatic t_edge_presc_r8;
        int n = 0;
        set_edge_mode(1'b0);
        presc_i = 2'd3; tick_i = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (clr_req_o) n++;
        end
        check("R8 tick ignored in edge mode", n, 0);
        for (int k = 0; k < 2; k++) begin
            evt_i = 1'b1;
            repeat (5) begin @(negedge clk); if (clr_req_o) n++; end
            evt_i = 1'b0;
            repeat (5) begin @(negedge clk); if (clr_req_o) n++; end
        end
        tick_i = 1'b0; presc_i = 2'd0;
        check("R8 every edge triggers with div-8 code", n, 2);
        trig_mode_i = 2'd0;
    endtask

    task automatic t_gate_r9;
        @(negedge clk);
        trig_mode_i = 2'd0; pol_i = 1'b0; evt_i = 1'b0; gate_en_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 idle low pol0 open", int'(cnt_gate_o), 1);
        evt_i = 1'b1;
        @(negedge clk); check("R9 pol0 before sync", int'(cnt_gate_o), 1);
        @(negedge clk); check("R9 pol0 high gated", int'(cnt_gate_o), 0);
        pol_i = 1'b1;
        #1 check("R9 pol1 high open", int'(cnt_gate_o), 1);
        @(negedge clk);
        evt_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 pol1 low gated", int'(cnt_gate_o), 0);
        gate_en_i = 1'b0;
        #1 check("R9 gate disabled open", int'(cnt_gate_o), 1);
        @(negedge clk);
        pol_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_compare();
        t_presc_r3();
        t_edge_r7(1'b0);
        t_edge_r7(1'b1);
        t_edge_presc_r8();
        t_gate_r9();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule